// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block carries data for one DMA channel. Software programs a source address, a destination address, an item count, a request selector and a control word through a narrow write-only configuration port. Once the enable bit is set, the engine moves items one at a time. Each item is one read on a generic memory port, followed by one write. The source and the destination each have their own item width and their own address-increment switch.

A transfer burst starts when the selected peripheral request line is high. In memory-to-memory mode a burst starts without any request. A burst moves at most 2^R items, where R is the burst field. The engine then releases the bus for one idle cycle, so that an outside arbiter can re-arbitrate. The channel priority field is passed out for that arbiter.

Two single-cycle event pulses mark the progress of the job: half-way and complete. In circular mode, completion reloads the count and both addresses from the values last programmed, and the channel keeps running. Otherwise completion drops the enable bit.

Top module: `dma_channel`

## Requirements
- R1: After reset, `chan_en` and `chan_prio` are 0 and no bus cycle is issued. Writing the control word with bit 0 clear while the channel is enabled stops it at once and zeroes every channel register, including the count and the selector.
- R2: Register offsets on `cfg_addr` are 0 source, 1 destination, 2 count, 3 control and 4 selector. While the channel is enabled, writes to offsets 0, 1, 2 and 4 are ignored, as are control writes that keep bit 0 set.
- R3: Each item is one read cycle (`bus_we`=0, address = current source), followed directly by one write cycle (`bus_we`=1, address = current destination). A cycle completes on `bus_ack`. `bus_size` carries that side's width code.
- R4: Control bits [4:3] hold the source width and bits [7:6] the destination width (0 byte, 1 halfword, 2 word, 3 treated as word). Bit 5 enables source increment and bit 8 enables destination increment. After each item, an address advances by 1, 2 or 4 only when its increment bit is set.
- R5: The written data is the read data truncated to the source width and zero-extended. Data sits in the low-order bits of the bus.
- R6: `evt_half` pulses once per pass, in the cycle after the item that leaves floor(N/2) items remaining. N is the programmed count, and the pulse occurs only when N ≥ 2.
- R7: `evt_done` pulses in the cycle after the last item. Without circular mode (control bit 1), `chan_en` is low from that same cycle on.
- R8: With circular mode set and a non-zero count, completion reloads the count and both addresses and leaves the channel enabled.
- R9: Control bits [14:11] hold R. A burst carries up to 2^R items back to back, then `bus_req` is low for at least one cycle. Memory-to-memory mode (control bit 2) starts bursts without a request.
- R10: Selector bits [3:0] hold the source select S and bits [7:4] hold the signal select G. With S ≥ 1, line (S−1)·NUM_SIG+G of `periph_req` triggers bursts, and every other line is ignored.
- R11: A count of zero at enable gives an `evt_done` pulse with no bus cycle and clears the enable, even in circular mode.
- R12: `chan_prio` shows control bits [10:9] while they are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Configuration write data |
| periph_req | input | NUM_SRC*NUM_SIG | Peripheral request lines |
| bus_req | output | 1 | Memory cycle request |
| bus_we | output | 1 | 1 for a write cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_size | output | 2 | Width code of the cycle |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_rdata | input | 32 | Read data, low-aligned |
| bus_ack | input | 1 | Cycle completion |
| evt_half | output | 1 | Half-transfer pulse |
| evt_done | output | 1 | Transfer-complete pulse |
| chan_en | output | 1 | Channel enable state |
| chan_prio | output | 2 | Channel priority |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 16-bit count, and four sources by four signals, which gives sixteen request lines. That is wide enough to place a request on a line away from line 0 and to show that neighbouring lines have no effect. Short counts (0, 2, 3 and 4), together with burst exponents 0, 1 and 3, bring the burst idle gaps, odd-count half points, a circular wrap and the zero-count shortcut within reach in a few hundred cycles.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

    localparam int BURST_FW = 4;
    localparam int BL_W     = 1 << BURST_FW;
    localparam int SEL_W    = 4;
    localparam int DATA_W   = 32;

    localparam logic [2:0] OFS_SRC  = 3'd0;
    localparam logic [2:0] OFS_DST  = 3'd1;
    localparam logic [2:0] OFS_CNT  = 3'd2;
    localparam logic [2:0] OFS_CTRL = 3'd3;
    localparam logic [2:0] OFS_SEL  = 3'd4;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_st_e;

    // Field order gives: en=0, circ=1, m2m=2, swid=4:3, sinc=5,
    // dwid=7:6, dinc=8, prio=10:9, burst=14:11
    typedef struct packed {
        logic [BURST_FW-1:0] burst;
        logic [1:0]          prio;
        logic                dinc;
        logic [1:0]          dwid;
        logic                sinc;
        logic [1:0]          swid;
        logic                m2m;
        logic                circ;
        logic                en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic width_e legal_width(input logic [1:0] code);
        return (code == 2'd3) ? W_WORD : width_e'(code);
    endfunction

    function automatic logic [2:0] width_bytes(input width_e w);
        case (w)
            W_BYTE:  return 3'd1;
            W_HALF:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] clip(input logic [DATA_W-1:0] d, input width_e w);
        case (w)
            W_BYTE:  return {{(DATA_W-8){1'b0}}, d[7:0]};
            W_HALF:  return {{(DATA_W-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
    import dma_ch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              step_i,
    input  logic              finish_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  total_o,
    output logic              en_o,
    output logic              m2m_o,
    output logic [BURST_FW-1:0] burst_o,
    output width_e            swid_o,
    output width_e            dwid_o,
    output logic [1:0]        prio_o,
    output logic [SEL_W-1:0]  sel_src_o,
    output logic [SEL_W-1:0]  sel_sig_o
);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] src_q, dst_q, src_sh, dst_sh;
    logic [CNT_W-1:0]  cnt_q, cnt_sh;
    logic [SEL_W-1:0]  ssrc_q, ssig_q;

    logic cfg_open, abort, keep_running;
    width_e sw, dw;

    assign cfg_open     = cfg_we && !ctrl_q.en;
    assign abort        = cfg_we && ctrl_q.en && (cfg_addr == OFS_CTRL) && !cfg_wdata[0];
    assign keep_running = ctrl_q.circ && (cnt_sh != '0);
    assign sw           = legal_width(ctrl_q.swid);
    assign dw           = legal_width(ctrl_q.dwid);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            ctrl_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            src_sh <= '0;
            dst_sh <= '0;
            cnt_q  <= '0;
            cnt_sh <= '0;
            ssrc_q <= '0;
            ssig_q <= '0;
        end else if (cfg_open) begin
            case (cfg_addr)
                OFS_SRC:  begin src_q <= cfg_wdata[ADDR_W-1:0]; src_sh <= cfg_wdata[ADDR_W-1:0]; end
                OFS_DST:  begin dst_q <= cfg_wdata[ADDR_W-1:0]; dst_sh <= cfg_wdata[ADDR_W-1:0]; end
                OFS_CNT:  begin cnt_q <= cfg_wdata[CNT_W-1:0];  cnt_sh <= cfg_wdata[CNT_W-1:0];  end
                OFS_CTRL: ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                OFS_SEL:  begin ssrc_q <= cfg_wdata[SEL_W-1:0]; ssig_q <= cfg_wdata[2*SEL_W-1:SEL_W]; end
                default:  ;
            endcase
        end else begin
            if (step_i) begin
                if (ctrl_q.sinc) src_q <= src_q + ADDR_W'(width_bytes(sw));
                if (ctrl_q.dinc) dst_q <= dst_q + ADDR_W'(width_bytes(dw));
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (finish_i) begin
                if (keep_running) begin
                    src_q <= src_sh;
                    dst_q <= dst_sh;
                    cnt_q <= cnt_sh;
                end else begin
                    ctrl_q.en <= 1'b0;
                end
            end
        end
    end

    assign src_o     = src_q;
    assign dst_o     = dst_q;
    assign cnt_o     = cnt_q;
    assign total_o   = cnt_sh;
    assign en_o      = ctrl_q.en;
    assign m2m_o     = ctrl_q.m2m;
    assign burst_o   = ctrl_q.burst;
    assign swid_o    = sw;
    assign dwid_o    = dw;
    assign prio_o    = ctrl_q.prio;
    assign sel_src_o = ssrc_q;
    assign sel_sig_o = ssig_q;

    p_cnt_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !finish_i && !abort && !cfg_open) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_done_clears_en_r7: assert property (@(posedge clk) disable iff (rst)
        (finish_i && !keep_running) |=> !ctrl_q.en);

endmodule

// File: rtl/dma_ch_reqsel.sv
module dma_ch_reqsel
    import dma_ch_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_SIG = 4
) (
    input  logic [NUM_SRC*NUM_SIG-1:0] periph_req,
    input  logic [SEL_W-1:0]           sel_src,
    input  logic [SEL_W-1:0]           sel_sig,
    output logic                       hit
);

    localparam int NUM_REQ = NUM_SRC * NUM_SIG;

    logic [NUM_REQ-1:0] match;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
        assign match[i] = (sel_src == SEL_W'(i / NUM_SIG + 1))
                       && (sel_sig == SEL_W'(i % NUM_SIG));
    end

    assign hit = |(match & periph_req);

endmodule

// File: rtl/dma_ch_xfer.sv
module dma_ch_xfer
    import dma_ch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                m2m_i,
    input  logic [BURST_FW-1:0] burst_i,
    input  width_e              swid_i,
    input  width_e              dwid_i,
    input  logic [ADDR_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]   dst_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [CNT_W-1:0]    total_i,
    input  logic                req_hit_i,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [1:0]          bus_size,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_ack,
    output logic                step_o,
    output logic                finish_o,
    output logic                evt_half,
    output logic                evt_done
);

    xfer_st_e          state;
    logic [BL_W-1:0]   bleft;
    logic [DATA_W-1:0] data_q;
    logic              last_item;

    assign last_item = (cnt_i == CNT_W'(1));

    always_comb begin
        step_o   = 1'b0;
        finish_o = 1'b0;
        case (state)
            ST_IDLE: finish_o = en_i && (cnt_i == '0);
            ST_WR: begin
                step_o   = en_i && bus_ack;
                finish_o = en_i && bus_ack && last_item;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bleft    <= '0;
            data_q   <= '0;
            evt_half <= 1'b0;
            evt_done <= 1'b0;
        end else begin
            evt_done <= finish_o;
            evt_half <= step_o && (total_i >= CNT_W'(2))
                     && ((cnt_i - CNT_W'(1)) == (total_i >> 1));
            case (state)
                ST_IDLE: begin
                    if (en_i && (cnt_i != '0) && (m2m_i || req_hit_i)) begin
                        state <= ST_RD;
                        bleft <= BL_W'(1) << burst_i;
                    end
                end
                ST_RD: begin
                    if (!en_i) begin
                        state <= ST_IDLE;
                    end else if (bus_ack) begin
                        data_q <= clip(bus_rdata, swid_i);
                        state  <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (!en_i) begin
                        state <= ST_IDLE;
                    end else if (bus_ack) begin
                        if (last_item || (bleft == BL_W'(1))) begin
                            state <= ST_IDLE;
                        end else begin
                            bleft <= bleft - BL_W'(1);
                            state <= ST_RD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (state != ST_IDLE);
    assign bus_we    = (state == ST_WR);
    assign bus_addr  = (state == ST_WR) ? dst_i : src_i;
    assign bus_size  = (state == ST_WR) ? dwid_i : swid_i;
    assign bus_wdata = data_q;

    p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && en_i && bus_ack) |=> (bus_req && bus_we));

    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !bus_req);

    p_size_legal_r5: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_size != 2'd3));

    p_half_total_r6: assert property (@(posedge clk) disable iff (rst)
        evt_half |-> ($past(total_i) >= CNT_W'(2)));

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_ch_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_SRC = 4,
    parameter int NUM_SIG = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_addr,
    input  logic [31:0]                cfg_wdata,
    input  logic [NUM_SRC*NUM_SIG-1:0] periph_req,
    output logic                       bus_req,
    output logic                       bus_we,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [1:0]                 bus_size,
    output logic [31:0]                bus_wdata,
    input  logic [31:0]                bus_rdata,
    input  logic                       bus_ack,
    output logic                       evt_half,
    output logic                       evt_done,
    output logic                       chan_en,
    output logic [1:0]                 chan_prio
);

    logic [ADDR_W-1:0]   src, dst;
    logic [CNT_W-1:0]    cnt, total;
    logic                en, m2m, step, finish, hit;
    logic [BURST_FW-1:0] burst;
    width_e              swid, dwid;
    logic [SEL_W-1:0]    sel_src, sel_sig;

    dma_ch_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .step_i(step), .finish_i(finish),
        .src_o(src), .dst_o(dst), .cnt_o(cnt), .total_o(total),
        .en_o(en), .m2m_o(m2m), .burst_o(burst),
        .swid_o(swid), .dwid_o(dwid), .prio_o(chan_prio),
        .sel_src_o(sel_src), .sel_sig_o(sel_sig)
    );

    dma_ch_reqsel #(.NUM_SRC(NUM_SRC), .NUM_SIG(NUM_SIG)) u_sel (
        .periph_req(periph_req), .sel_src(sel_src), .sel_sig(sel_sig), .hit(hit)
    );

    dma_ch_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst(rst),
        .en_i(en), .m2m_i(m2m), .burst_i(burst),
        .swid_i(swid), .dwid_i(dwid),
        .src_i(src), .dst_i(dst), .cnt_i(cnt), .total_i(total),
        .req_hit_i(hit),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack),
        .step_o(step), .finish_o(finish),
        .evt_half(evt_half), .evt_done(evt_done)
    );

    assign chan_en = en;

endmodule

// File: tb/dma_channel_tb.sv
module dma_channel_tb;

    localparam int CLK_P   = 10;
    localparam int NUM_SRC = 4;
    localparam int NUM_SIG = 4;
    localparam int NREQ    = NUM_SRC * NUM_SIG;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [NREQ-1:0] periph_req = '0;
    logic            bus_req, bus_we, evt_half, evt_done, chan_en;
    logic [31:0]     bus_addr, bus_wdata;
    logic [31:0]     bus_rdata = '0;
    logic            bus_ack = 1'b0;
    logic [1:0]      bus_size, chan_prio;

    int checks = 0, fails = 0;
    int n_rd = 0, n_wr = 0, n_half = 0, n_done = 0, n_burst = 0;
    logic prev_req = 1'b0;
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    logic [1:0]  wr_size [64];
    logic [31:0] rd_addr [64];
    logic [1:0]  rd_size [64];

    always #(CLK_P/2) clk = ~clk;

    dma_channel #(.NUM_SRC(NUM_SRC), .NUM_SIG(NUM_SIG)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .periph_req(periph_req), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .evt_half(evt_half), .evt_done(evt_done), .chan_en(chan_en), .chan_prio(chan_prio)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0] + 16'h5A00, ~a[15:0]};
    endfunction

    function automatic logic [31:0] mkctrl(input bit en, input bit circ, input bit m2m,
                                           input int sw, input bit si, input int dw, input bit di,
                                           input int prio, input int burst);
        return {17'd0, 4'(burst), 2'(prio), di, 2'(dw), si, 2'(sw), m2m, circ, en};
    endfunction

    // Bus slave and event monitor, all on the falling edge
    always @(negedge clk) begin
        bus_rdata = mem_val(bus_addr);
        if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_we) begin
                if (n_wr < 64) begin
                    wr_addr[n_wr] = bus_addr; wr_data[n_wr] = bus_wdata; wr_size[n_wr] = bus_size;
                end
                n_wr++;
            end else begin
                if (n_rd < 64) begin
                    rd_addr[n_rd] = bus_addr; rd_size[n_rd] = bus_size;
                end
                n_rd++;
            end
        end else begin
            bus_ack = 1'b0;
        end
        if (evt_half) n_half++;
        if (evt_done) n_done++;
        if (bus_req && !prev_req) n_burst++;
        prev_req = bus_req;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        periph_req = '0;
        cfg_we = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_half = 0; n_done = 0; n_burst = 0;
    endtask

    task automatic wait_done(input int target, input string req);
        int k = 0;
        while (n_done < target && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " completion reached"}, 32'(n_done >= target), 32'd1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 enable after reset", 32'(chan_en), 0);
        chk("R1 no bus after reset", 32'(bus_req), 0);
        chk("R12 prio after reset", 32'(chan_prio), 0);
        chk("R7 no done after reset", 32'(evt_done), 0);
    endtask

    task automatic t_m2m_words();
        do_reset();
        wr(3'd0, 32'h100);
        wr(3'd1, 32'h200);
        wr(3'd2, 32'd4);
        wr(3'd3, mkctrl(1, 0, 1, 2, 1, 2, 1, 3, 1));
        chk("R12 prio shown", 32'(chan_prio), 3);
        wait_done(1, "R7");
        repeat (3) @(negedge clk);
        chk("R3 write count", n_wr, 4);
        chk("R3 read count", n_rd, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R4 word src step", rd_addr[i], 32'h100 + 4*i);
            chk("R4 word dst step", wr_addr[i], 32'h200 + 4*i);
            chk("R3 data moved", wr_data[i], mem_val(32'h100 + 4*i));
            chk("R3 write size", 32'(wr_size[i]), 2);
        end
        chk("R6 one half pulse", n_half, 1);
        chk("R7 one done pulse", n_done, 1);
        chk("R7 enable dropped", 32'(chan_en), 0);
        chk("R9 two bursts of 2", n_burst, 2);
    endtask

    task automatic t_mixed_width();
        do_reset();
        wr(3'd0, 32'h31);
        wr(3'd1, 32'h80);
        wr(3'd2, 32'd3);
        wr(3'd3, mkctrl(1, 0, 1, 0, 1, 1, 0, 0, 3));
        wait_done(1, "R7");
        repeat (3) @(negedge clk);
        chk("R3 write count mixed", n_wr, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 byte src step", rd_addr[i], 32'h31 + i);
            chk("R5 read size byte", 32'(rd_size[i]), 0);
            chk("R4 fixed dst", wr_addr[i], 32'h80);
            chk("R5 write size half", 32'(wr_size[i]), 1);
            chk("R5 truncated data", wr_data[i], mem_val(32'h31 + i) & 32'hFF);
        end
        chk("R6 half on odd count", n_half, 1);
        chk("R9 single burst of 8", n_burst, 1);
    endtask

    task automatic t_periph();
        do_reset();
        wr(3'd0, 32'h500);
        wr(3'd1, 32'h600);
        wr(3'd2, 32'd3);
        wr(3'd4, {24'd0, 4'd3, 4'd2});     // S=2 G=3 -> line 7
        wr(3'd3, mkctrl(1, 0, 0, 2, 1, 2, 1, 1, 0));
        repeat (20) @(negedge clk);
        chk("R10 idle without request", n_rd, 0);
        wr(3'd0, 32'h900);                 // ignored while enabled
        wr(3'd2, 32'd9);                   // ignored while enabled
        periph_req[6]  = 1'b1;
        periph_req[11] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 other lines ignored", n_rd, 0);
        periph_req[7] = 1'b1;
        wait_done(1, "R10");
        periph_req = '0;
        repeat (3) @(negedge clk);
        chk("R2 source write ignored", rd_addr[0], 32'h500);
        chk("R2 count write ignored", n_wr, 3);
        chk("R9 one item per burst", n_burst, 3);
        chk("R10 last dst", wr_addr[2], 32'h608);
    endtask

    task automatic t_circular();
        do_reset();
        wr(3'd0, 32'h300);
        wr(3'd1, 32'h400);
        wr(3'd2, 32'd2);
        wr(3'd3, mkctrl(1, 1, 1, 0, 1, 0, 1, 1, 0));
        wait_done(1, "R8");
        chk("R8 stays enabled", 32'(chan_en), 1);
        wait_done(2, "R8");
        wr(3'd3, 32'd0);
        chk("R1 disable stops", 32'(chan_en), 0);
        chk("R1 prio cleared", 32'(chan_prio), 0);
        chk("R8 addr wrap src", rd_addr[2], 32'h300);
        chk("R8 addr wrap src2", rd_addr[3], 32'h301);
        chk("R8 addr wrap dst", wr_addr[2], 32'h400);
        chk("R8 addr wrap dst2", wr_addr[3], 32'h401);
        chk("R6 half each pass", 32'(n_half >= 2), 1);
        repeat (3) @(negedge clk);
        begin
            int wr_before = n_wr;
            int done_before = n_done;
            wr(3'd3, mkctrl(1, 0, 1, 0, 1, 0, 1, 0, 0));
            repeat (5) @(negedge clk);
            chk("R1 count cleared by disable", n_wr, wr_before);
            chk("R11 done after cleared count", n_done, done_before + 1);
        end
    endtask

    task automatic t_zero();
        do_reset();
        wr(3'd0, 32'h700);
        wr(3'd3, mkctrl(1, 1, 1, 2, 1, 2, 1, 0, 0));
        repeat (6) @(negedge clk);
        chk("R11 single done", n_done, 1);
        chk("R11 no bus cycles", n_rd + n_wr, 0);
        chk("R11 enable cleared", 32'(chan_en), 0);
        chk("R11 no half", n_half, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_m2m_words();
        t_mixed_width();
        t_periph();
        t_circular();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule